// File: doc/BRIEF.md
# Round-Robin Multi-Channel Burst Copy Engine

This block copies word-aligned memory buffers for several independent channels through a single 32-bit bus-master port. A channel is loaded by a one-cycle start pulse carrying its source address, destination address and byte length. From then on it competes for the master port. The winning channel gets one burst: the engine reads up to a fixed number of words into a local staging buffer, then writes the same words to the destination. After that burst the port goes to the next channel that is waiting, in index order.

Each channel keeps its own current source, destination and remaining byte count, and these advance after every completed burst. A final short burst carries whatever is left when the length is not a whole number of bursts. Each channel reports a 3-bit status. A bus error ends the channel with a code that says whether the read side or the write side failed. An abort pulse returns a channel to idle. If the engine is in the middle of an access for that channel, the access finishes first.

Top module: `dma_rr_top`

## Requirements
- R1: After reset every channel status reads 0 (idle) and `m_req_valid_o` is low.
- R2: A start pulse with a nonzero length on a channel whose status is not 1 sets the status to 1 (busy) one cycle later. All length/4 words are copied from source to destination, the destination word just past the buffer is not written, and the status then becomes 2 (done).
- R3: A start pulse with length 0 sets the status to 2 one cycle later and issues no bus request.
- R4: Each grant issues k reads at consecutive word addresses from the channel's current source, followed by k writes at consecutive addresses from its current destination. k = min(MAXB/4, remaining bytes/4), so the last burst of a length that is not a multiple of MAXB carries only the leftover words.
- R5: While several channels are busy, successive bursts go to the busy channels in rising index order, wrapping around, with exactly one burst per grant.
- R6: An error response to a read ends the channel with status 3, and no further request is made for it.
- R7: An error response to a write ends the channel with status 4, and no further request is made for it.
- R8: An abort of a busy channel that does not hold the port sets its status to 0 one cycle later. An abort of the channel that holds the port lets at most one more request for it complete, then sets status 0, and the engine goes on serving other channels.
- R9: A start pulse on a busy channel is ignored: the running transfer finishes unchanged and the new destination is never written.
- R10: The master port has at most one request outstanding. A new request is presented only after the response to the previous one, and a presented request keeps its address, direction and data until accepted.
- R11: An abort of a channel in status done or error returns it to status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | NCH | Per-channel start pulse |
| abort_i | input | NCH | Per-channel abort pulse |
| src_i | input | NCH*AW | Source byte address per channel, word aligned |
| dst_i | input | NCH*AW | Destination byte address per channel, word aligned |
| len_i | input | NCH*LW | Transfer length in bytes per channel, multiple of 4 |
| stat_o | output | NCH*3 | Status per channel: 0 idle, 1 busy, 2 done, 3 read error, 4 write error |
| m_req_valid_o | output | 1 | Master request valid |
| m_req_ready_i | input | 1 | Master request accepted |
| m_req_we_o | output | 1 | Request is a write (1) or read (0) |
| m_req_addr_o | output | AW | Request byte address |
| m_req_wdata_o | output | 32 | Write data |
| m_rsp_valid_i | input | 1 | Response valid |
| m_rsp_ready_o | output | 1 | Engine can take a response |
| m_rsp_err_i | input | 1 | Response carries an error |
| m_rsp_rdata_i | input | 32 | Read response data |

## Verification
The assertions assume the following about the inputs: addresses and lengths are word aligned, start and abort are single-cycle pulses, and the bus side returns exactly one response for each accepted request, only while `m_rsp_ready_o` is high. The bench memory model accepts requests on a fixed stall pattern and answers each one a cycle later. It holds its response until it is taken and never volunteers an unsolicited one. All lengths and addresses it drives are multiples of four inside disjoint per-channel regions, so burst counts and copied words can be predicted arithmetically.

// File: rtl/dma_rr_pkg.sv
package dma_rr_pkg;
  typedef enum logic [2:0] {
    CH_IDLE  = 3'd0,
    CH_BUSY  = 3'd1,
    CH_DONE  = 3'd2,
    CH_RDERR = 3'd3,
    CH_WRERR = 3'd4
  } ch_stat_e;

  typedef enum logic [2:0] {
    E_ARB, E_RREQ, E_RRSP, E_WREQ, E_WRSP
  } eng_st_e;
endpackage

// File: rtl/dma_rr_chan.sv
module dma_rr_chan
  import dma_rr_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [LW-1:0] len_i,
  input  logic          active_i,
  input  logic          adv_i,
  input  logic [LW-1:0] step_i,
  input  logic          fin_i,
  input  ch_stat_e      fin_code_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [LW-1:0] rem_o,
  output ch_stat_e      stat_o,
  output logic          abp_o
);
  logic [AW-1:0] src_q, src_n, dst_q, dst_n;
  logic [LW-1:0] rem_q, rem_n;
  ch_stat_e      stat_q, stat_n;
  logic          abp_q, abp_n, en;

  always_comb begin
    src_n  = src_q;
    dst_n  = dst_q;
    rem_n  = rem_q;
    stat_n = stat_q;
    abp_n  = abp_q;
    if (adv_i) begin
      src_n = src_q + AW'(step_i);
      dst_n = dst_q + AW'(step_i);
      rem_n = rem_q - step_i;
    end
    if (fin_i) begin
      stat_n = fin_code_i;
      abp_n  = 1'b0;
    end
    if (abort_i) begin
      if (stat_n == CH_BUSY && active_i) begin
        abp_n = 1'b1;
      end else begin
        stat_n = CH_IDLE;
        abp_n  = 1'b0;
      end
    end else if (start_i && stat_n != CH_BUSY) begin
      src_n  = src_i;
      dst_n  = dst_i;
      rem_n  = len_i;
      stat_n = (len_i == '0) ? CH_DONE : CH_BUSY;
    end
  end

  assign en = adv_i | fin_i | abort_i | start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      rem_q  <= '0;
      stat_q <= CH_IDLE;
      abp_q  <= 1'b0;
    end else if (en) begin
      src_q  <= src_n;
      dst_q  <= dst_n;
      rem_q  <= rem_n;
      stat_q <= stat_n;
      abp_q  <= abp_n;
    end
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign rem_o  = rem_q;
  assign stat_o = stat_q;
  assign abp_o  = abp_q;

  // R3
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !abort_i && stat_q != CH_BUSY && len_i == '0) |=> stat_q == CH_DONE);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !abort_i && stat_q == CH_BUSY && !fin_i && !adv_i)
      |=> ($stable(src_q) && $stable(dst_q) && $stable(rem_q)));

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !active_i) |=> stat_q == CH_IDLE);
endmodule

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic           take_i,
  output logic           any_o,
  output logic [IW-1:0]  idx_o
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    int c;
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 1; i <= NCH; i++) begin
      c = (int'(ptr_q) + i) % NCH;
      if (!any_o && req_i[c]) begin
        any_o = 1'b1;
        idx_o = IW'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= IW'(NCH - 1);
    end else if (take_i) begin
      ptr_q <= idx_o;
    end
  end

  // R5
  gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> req_i[idx_o]);
endmodule

// File: rtl/dma_rr_engine.sv
module dma_rr_engine
  import dma_rr_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int AW   = 32,
  parameter int LW   = 16,
  parameter int MAXB = 16,
  localparam int BW  = MAXB / 4,
  localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IXW = (BW > 1) ? $clog2(BW) : 1,
  localparam int CW  = $clog2(BW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  abort_i,
  input  logic [NCH-1:0]  abp_i,
  input  logic [NCH*AW-1:0] src_all_i,
  input  logic [NCH*AW-1:0] dst_all_i,
  input  logic [NCH*LW-1:0] rem_all_i,
  input  logic            any_i,
  input  logic [IW-1:0]   pick_i,
  output logic            take_o,
  output logic            act_o,
  output logic [IW-1:0]   gnt_o,
  output logic            adv_o,
  output logic            fin_o,
  output ch_stat_e        fin_code_o,
  output logic [LW-1:0]   step_o,
  output logic            m_req_valid_o,
  input  logic            m_req_ready_i,
  output logic            m_req_we_o,
  output logic [AW-1:0]   m_req_addr_o,
  output logic [31:0]     m_req_wdata_o,
  input  logic            m_rsp_valid_i,
  output logic            m_rsp_ready_o,
  input  logic            m_rsp_err_i,
  input  logic [31:0]     m_rsp_rdata_i
);
  eng_st_e        st_q, st_n;
  logic [IW-1:0]  gnt_q, gnt_n;
  logic [IXW-1:0] idx_q, idx_n;
  logic [CW-1:0]  nw_q, nw_n, words_p;
  logic [31:0]    buf_q [BW];
  logic           buf_we, req_hs, rsp_hs, last, abp_eff;
  logic [AW-1:0]  src_c, dst_c;
  logic [LW-1:0]  rem_c, rem_p;

  assign src_c   = src_all_i[gnt_q*AW +: AW];
  assign dst_c   = dst_all_i[gnt_q*AW +: AW];
  assign rem_c   = rem_all_i[gnt_q*LW +: LW];
  assign rem_p   = rem_all_i[pick_i*LW +: LW];
  assign words_p = (rem_p >= LW'(MAXB)) ? CW'(BW) : rem_p[CW+1:2];
  assign req_hs  = m_req_valid_o && m_req_ready_i;
  assign rsp_hs  = m_rsp_valid_i && m_rsp_ready_o;
  assign last    = CW'(idx_q) == (nw_q - CW'(1));
  assign abp_eff = abp_i[gnt_q] | abort_i[gnt_q];
  assign step_o  = LW'({nw_q, 2'b00});

  always_comb begin
    st_n       = st_q;
    gnt_n      = gnt_q;
    idx_n      = idx_q;
    nw_n       = nw_q;
    take_o     = 1'b0;
    adv_o      = 1'b0;
    fin_o      = 1'b0;
    fin_code_o = CH_IDLE;
    buf_we     = 1'b0;
    case (st_q)
      E_ARB: if (any_i) begin
        take_o = 1'b1;
        gnt_n  = pick_i;
        nw_n   = words_p;
        idx_n  = '0;
        st_n   = E_RREQ;
      end
      E_RREQ: if (req_hs) st_n = E_RRSP;
      E_RRSP: if (rsp_hs) begin
        buf_we = !m_rsp_err_i;
        if (m_rsp_err_i) begin
          fin_o = 1'b1; fin_code_o = CH_RDERR; st_n = E_ARB;
        end else if (abp_eff) begin
          fin_o = 1'b1; fin_code_o = CH_IDLE; st_n = E_ARB;
        end else if (last) begin
          idx_n = '0; st_n = E_WREQ;
        end else begin
          idx_n = idx_q + IXW'(1); st_n = E_RREQ;
        end
      end
      E_WREQ: if (req_hs) st_n = E_WRSP;
      E_WRSP: if (rsp_hs) begin
        if (m_rsp_err_i) begin
          fin_o = 1'b1; fin_code_o = CH_WRERR; st_n = E_ARB;
        end else if (abp_eff) begin
          fin_o = 1'b1; fin_code_o = CH_IDLE; st_n = E_ARB;
        end else if (last) begin
          adv_o = 1'b1;
          if (rem_c == step_o) begin
            fin_o = 1'b1; fin_code_o = CH_DONE;
          end
          st_n = E_ARB;
        end else begin
          idx_n = idx_q + IXW'(1); st_n = E_WREQ;
        end
      end
      default: st_n = E_ARB;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= E_ARB;
      gnt_q <= '0;
      idx_q <= '0;
      nw_q  <= '0;
    end else begin
      st_q  <= st_n;
      gnt_q <= gnt_n;
      idx_q <= idx_n;
      nw_q  <= nw_n;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) buf_q[idx_q] <= m_rsp_rdata_i;
  end

  assign act_o         = st_q != E_ARB;
  assign gnt_o         = gnt_q;
  assign m_req_valid_o = (st_q == E_RREQ) || (st_q == E_WREQ);
  assign m_req_we_o    = st_q == E_WREQ;
  assign m_req_addr_o  = ((st_q == E_WREQ) ? dst_c : src_c) + AW'({idx_q, 2'b00});
  assign m_req_wdata_o = buf_q[idx_q];
  assign m_rsp_ready_o = (st_q == E_RRSP) || (st_q == E_WRSP);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req_valid_o && !m_req_ready_i) |=>
      (m_req_valid_o && $stable(m_req_addr_o) && $stable(m_req_we_o) && $stable(m_req_wdata_o)));

  // R10
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_hs |=> !m_req_valid_o);

  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != E_ARB) |-> (nw_q != '0 && nw_q <= CW'(BW)));

  // R6
  rderr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_RRSP && rsp_hs && m_rsp_err_i) |=> st_q == E_ARB);
endmodule

// File: rtl/dma_rr_top.sv
module dma_rr_top
  import dma_rr_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int AW   = 32,
  parameter int LW   = 16,
  parameter int MAXB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    start_i,
  input  logic [NCH-1:0]    abort_i,
  input  logic [NCH*AW-1:0] src_i,
  input  logic [NCH*AW-1:0] dst_i,
  input  logic [NCH*LW-1:0] len_i,
  output logic [NCH*3-1:0]  stat_o,
  output logic              m_req_valid_o,
  input  logic              m_req_ready_i,
  output logic              m_req_we_o,
  output logic [AW-1:0]     m_req_addr_o,
  output logic [31:0]       m_req_wdata_o,
  input  logic              m_rsp_valid_i,
  output logic              m_rsp_ready_o,
  input  logic              m_rsp_err_i,
  input  logic [31:0]       m_rsp_rdata_i
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [1:0]        rs_q;
  logic              rst_sn;
  logic [NCH*AW-1:0] src_all, dst_all;
  logic [NCH*LW-1:0] rem_all;
  logic [NCH-1:0]    busy, abp, arb_req;
  logic              any, take, act, adv, fin;
  logic [IW-1:0]     pick, gnt;
  logic [LW-1:0]     step;
  ch_stat_e          fin_code;
  ch_stat_e          ch_stat [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic mine;
    assign mine = act && (gnt == IW'(k));
    dma_rr_chan #(.AW(AW), .LW(LW)) u_ch (
      .clk(clk), .rst_n(rst_sn),
      .start_i(start_i[k]), .abort_i(abort_i[k]),
      .src_i(src_i[k*AW +: AW]), .dst_i(dst_i[k*AW +: AW]), .len_i(len_i[k*LW +: LW]),
      .active_i(mine), .adv_i(adv && mine), .step_i(step),
      .fin_i(fin && mine), .fin_code_i(fin_code),
      .src_o(src_all[k*AW +: AW]), .dst_o(dst_all[k*AW +: AW]), .rem_o(rem_all[k*LW +: LW]),
      .stat_o(ch_stat[k]), .abp_o(abp[k])
    );
    assign busy[k]         = ch_stat[k] == CH_BUSY;
    assign stat_o[k*3 +: 3] = ch_stat[k];
  end

  assign arb_req = busy & ~abort_i;

  dma_rr_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_sn), .req_i(arb_req), .take_i(take),
    .any_o(any), .idx_o(pick)
  );

  dma_rr_engine #(.NCH(NCH), .AW(AW), .LW(LW), .MAXB(MAXB)) u_eng (
    .clk(clk), .rst_n(rst_sn),
    .abort_i(abort_i), .abp_i(abp),
    .src_all_i(src_all), .dst_all_i(dst_all), .rem_all_i(rem_all),
    .any_i(any), .pick_i(pick), .take_o(take), .act_o(act), .gnt_o(gnt),
    .adv_o(adv), .fin_o(fin), .fin_code_o(fin_code), .step_o(step),
    .m_req_valid_o(m_req_valid_o), .m_req_ready_i(m_req_ready_i),
    .m_req_we_o(m_req_we_o), .m_req_addr_o(m_req_addr_o), .m_req_wdata_o(m_req_wdata_o),
    .m_rsp_valid_i(m_rsp_valid_i), .m_rsp_ready_o(m_rsp_ready_o),
    .m_rsp_err_i(m_rsp_err_i), .m_rsp_rdata_i(m_rsp_rdata_i)
  );
endmodule

// File: tb/sim_dma_rr_top.sv
`timescale 1ns/1ps
module sim_dma_rr_top;
  localparam int NCH = 4, AW = 32, LW = 16, MAXB = 16, BW = MAXB / 4;

  logic clk, rst_n;
  logic [NCH-1:0] start_i, abort_i;
  logic [NCH*AW-1:0] src_i, dst_i;
  logic [NCH*LW-1:0] len_i;
  logic [NCH*3-1:0] stat_o;
  logic m_req_valid, m_req_ready, m_req_we, m_rsp_valid, m_rsp_ready, m_rsp_err;
  logic [AW-1:0] m_req_addr;
  logic [31:0] m_req_wdata, m_rsp_rdata;

  dma_rr_top #(.NCH(NCH), .AW(AW), .LW(LW), .MAXB(MAXB)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .src_i(src_i), .dst_i(dst_i), .len_i(len_i), .stat_o(stat_o),
    .m_req_valid_o(m_req_valid), .m_req_ready_i(m_req_ready), .m_req_we_o(m_req_we),
    .m_req_addr_o(m_req_addr), .m_req_wdata_o(m_req_wdata),
    .m_rsp_valid_i(m_rsp_valid), .m_rsp_ready_o(m_rsp_ready),
    .m_rsp_err_i(m_rsp_err), .m_rsp_rdata_i(m_rsp_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] mem [0:4095];
  int total = 0, bad = 0, viol = 0, cyc = 0, bl_n = 0;
  int req_cnt [NCH];
  int bl_ch [0:255];
  int bl_rd [0:255];
  int bl_wr [0:255];
  bit hs_req_p = 0, hs_rsp_p = 0, bopen = 0, lwe = 0, err_en = 0, finished = 0;
  logic [31:0] p_data;
  logic p_err;
  logic [AW-1:0] err_addr = '0;

  function automatic logic [31:0] pat(input int i);
    return 32'(i) * 32'h9E37_79B1 + 32'h1234_5678;
  endfunction

  function automatic int st(input int k);
    return int'(stat_o[k*3 +: 3]);
  endfunction

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // bus memory model: one cycle response latency, stalls on a fixed pattern
  initial begin
    m_req_ready = 0; m_rsp_valid = 0; m_rsp_err = 0; m_rsp_rdata = '0;
    for (int i = 0; i < NCH; i++) req_cnt[i] = 0;
    forever begin
      int ch;
      @(negedge clk);
      cyc++;
      if (hs_rsp_p) begin m_rsp_valid = 0; m_rsp_err = 0; hs_rsp_p = 0; end
      if (hs_req_p) begin m_rsp_valid = 1; m_rsp_rdata = p_data; m_rsp_err = p_err; hs_req_p = 0; end
      m_req_ready = (cyc % 3) != 1;
      if (m_req_valid && m_req_ready) begin
        if (m_rsp_valid) viol++;
        ch = int'(m_req_addr[13:12]);
        req_cnt[ch]++;
        p_err = err_en && (m_req_addr == err_addr);
        if (!m_req_we) begin
          p_data = mem[m_req_addr[13:2]];
          if (!bopen || lwe || ch != bl_ch[bl_n-1]) begin
            if (bl_n < 256) bl_n++;
            bl_ch[bl_n-1] = ch; bl_rd[bl_n-1] = 0; bl_wr[bl_n-1] = 0;
          end
          bl_rd[bl_n-1]++;
        end else begin
          if (!p_err) mem[m_req_addr[13:2]] = m_req_wdata;
          if (bl_n > 0) bl_wr[bl_n-1]++;
        end
        lwe = m_req_we; bopen = 1;
        hs_req_p = 1;
      end
      if (m_rsp_valid && m_rsp_ready) hs_rsp_p = 1;
    end
  end

  task automatic init_mem();
    for (int i = 0; i < 4096; i++) mem[i] = ((i % 1024) < 512) ? pat(i) : 32'h0;
  endtask

  task automatic set_ch(input int k, input int src, input int dst, input int len);
    src_i[k*AW +: AW] = AW'(src);
    dst_i[k*AW +: AW] = AW'(dst);
    len_i[k*LW +: LW] = LW'(len);
  endtask

  task automatic pulse_start(input logic [NCH-1:0] m);
    start_i = m; @(posedge clk); #1; start_i = '0;
  endtask

  task automatic pulse_abort(input logic [NCH-1:0] m);
    abort_i = m; @(posedge clk); #1; abort_i = '0;
  endtask

  task automatic wait_free(input int k, input int limit);
    for (int i = 0; i < limit && st(k) == 1; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic burst_check(input int k, input int n, input string r);
    int nb, miss;
    nb = (n + BW - 1) / BW; miss = 0;
    if (bl_n != nb) miss++;
    for (int b = 0; b < nb && b < bl_n; b++) begin
      int e;
      e = (n - b * BW < BW) ? n - b * BW : BW;
      if (bl_ch[b] != k || bl_rd[b] != e || bl_wr[b] != e) miss++;
    end
    chk(miss == 0, r, bl_n, nb);
  endtask

  initial begin
    int rc;
    start_i = '0; abort_i = '0; src_i = '0; dst_i = '0; len_i = '0;
    init_mem();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    for (int k = 0; k < NCH; k++) chk(st(k) == 0, "R1 status", st(k), 0);
    chk(m_req_valid == 0, "R1 req_valid", m_req_valid, 0);

    // R2 / R4 length sweep on every channel
    for (int k = 0; k < NCH; k++) begin
      for (int n = 1; n <= 11; n++) begin
        int mism;
        init_mem();
        bl_n = 0; bopen = 0;
        set_ch(k, k * 4096, k * 4096 + 2048, n * 4);
        pulse_start(NCH'(1) << k);
        chk(st(k) == 1, "R2 busy", st(k), 1);
        wait_free(k, 2000);
        chk(st(k) == 2, "R2 done", st(k), 2);
        mism = 0;
        for (int j = 0; j < n; j++)
          if (mem[k * 1024 + 512 + j] !== pat(k * 1024 + j)) mism++;
        chk(mism == 0, "R2 data", mism, 0);
        chk(mem[k * 1024 + 512 + n] == 0, "R2 past end", mem[k * 1024 + 512 + n], 0);
        burst_check(k, n, "R4 bursts");
      end
    end

    // R3 zero length
    for (int k = 0; k < NCH; k++) begin
      rc = req_cnt[k];
      set_ch(k, k * 4096, k * 4096 + 2048, 0);
      pulse_start(NCH'(1) << k);
      chk(st(k) == 2, "R3 status", st(k), 2);
      repeat (10) @(posedge clk);
      #1;
      chk(req_cnt[k] == rc, "R3 no request", req_cnt[k], rc);
    end

    // R5 round robin among channels 0, 1, 3
    begin
      int mism, exp_ch [3];
      exp_ch[0] = 0; exp_ch[1] = 1; exp_ch[2] = 3;
      init_mem();
      bl_n = 0; bopen = 0;
      set_ch(0, 0, 2048, 96);
      set_ch(1, 4096, 4096 + 2048, 96);
      set_ch(3, 3 * 4096, 3 * 4096 + 2048, 96);
      pulse_start(4'b1011);
      wait_free(0, 5000); wait_free(1, 5000); wait_free(3, 5000);
      mism = 0;
      for (int b = 0; b < 18; b++) if (bl_ch[b] != exp_ch[b % 3] || bl_rd[b] != BW) mism++;
      chk(mism == 0 && bl_n == 18, "R5 order", mism, 0);
      mism = 0;
      for (int j = 0; j < 24; j++) begin
        if (mem[512 + j] !== pat(j)) mism++;
        if (mem[3 * 1024 + 512 + j] !== pat(3 * 1024 + j)) mism++;
      end
      chk(mism == 0, "R5 data", mism, 0);
    end

    // R6 read error on channel 1 at word 2
    rc = req_cnt[1];
    err_en = 1; err_addr = AW'(4096 + 8);
    set_ch(1, 4096, 4096 + 2048, 160);
    pulse_start(4'b0010);
    wait_free(1, 3000);
    chk(st(1) == 3, "R6 status", st(1), 3);
    chk(req_cnt[1] - rc == 3, "R6 requests", req_cnt[1] - rc, 3);
    err_en = 0;

    // R7 write error on channel 2 at destination word 5
    rc = req_cnt[2];
    err_en = 1; err_addr = AW'(2 * 4096 + 2048 + 20);
    set_ch(2, 2 * 4096, 2 * 4096 + 2048, 160);
    pulse_start(4'b0100);
    wait_free(2, 3000);
    chk(st(2) == 4, "R7 status", st(2), 4);
    chk(req_cnt[2] - rc == 14, "R7 requests", req_cnt[2] - rc, 14);
    err_en = 0;

    // R8 abort: channel 2 waiting, channel 0 holding the port
    begin
      int seen;
      set_ch(0, 0, 2048, 160);
      set_ch(2, 2 * 4096, 2 * 4096 + 2048, 160);
      pulse_start(4'b0101);
      seen = 0;
      for (int i = 0; i < 500 && seen == 0; i++) begin
        if (m_req_valid && m_req_addr[13:12] == 2'd0 && i > 20) seen = 1;
        else begin @(posedge clk); #1; end
      end
      rc = req_cnt[0];
      pulse_abort(4'b0101);
      chk(st(2) == 0, "R8 idle waiting ch", st(2), 0);
      wait_free(0, 20);
      chk(st(0) == 0, "R8 idle active ch", st(0), 0);
      chk(req_cnt[0] - rc <= 1, "R8 extra requests", req_cnt[0] - rc, 1);
      set_ch(1, 4096, 4096 + 2048, 32);
      pulse_start(4'b0010);
      wait_free(1, 2000);
      chk(st(1) == 2, "R8 engine continues", st(1), 2);
    end

    // R11 abort of a finished channel
    pulse_abort(4'b0010);
    chk(st(1) == 0, "R11 done to idle", st(1), 0);
    pulse_abort(4'b0100);
    chk(st(2) == 0, "R11 idle stays idle", st(2), 0);

    // R9 start on a busy channel ignored
    begin
      int mism;
      init_mem();
      set_ch(3, 3 * 4096, 3 * 4096 + 2048, 96);
      pulse_start(4'b1000);
      repeat (5) @(posedge clk);
      #1;
      set_ch(3, 3 * 4096, 3 * 4096 + 3072, 16);
      pulse_start(4'b1000);
      wait_free(3, 3000);
      chk(st(3) == 2, "R9 status", st(3), 2);
      mism = 0;
      for (int j = 0; j < 24; j++) if (mem[3 * 1024 + 512 + j] !== pat(3 * 1024 + j)) mism++;
      chk(mism == 0, "R9 first copy", mism, 0);
      chk(mem[3 * 1024 + 768] == 0, "R9 second dst untouched", mem[3 * 1024 + 768], 0);
    end

    // R10 at most one outstanding request
    chk(viol == 0, "R10 outstanding", viol, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule